// File: doc/BRIEF.md
# Dual-Rail Power-Good Delay Sequencer

This block produces a delayed power-good indication for two switching regulator rails. Each rail contributes an enable and a ready flag from an external threshold comparator. The ready flag rises once the rail is close to its target level and drops when the rail sags well below it. The output is an active-low reset, modelled as an open-drain pin. It stays low until a rail has been enabled and ready for a selectable hold-off time, and until both rails are either good or still inside their start-up grace window.

The hold-off timer starts on the first rail that becomes good. A second rail that becomes good while the hold-off is running does not restart it. A drop of either rail's good state restarts the hold-off and pulls the output low. Each enable rising edge opens a grace window on its own rail. During that window the rail counts as good, so a rail switched on after release does not glitch the output. If that rail is still not ready when its window closes, the output drops. All times are counted in ticks of an external timebase whose period is a parameter.

Top module: `pwr_good_seq`

## Requirements
- R1: While rst_ni is low, and right after it is released, npor_o is 0 and npor_oe_o is 1.
- R2: The hold-off length comes from dly_sel_i. Code 00 gives 50 ms (the value after reset), 01 gives 50 us, 10 gives 100 ms and 11 gives 200 ms. Each length is rounded up to whole ticks, which are 5000, 5, 10000 and 20000 ticks at the default 10 us tick. The hold-off starts at the clock edge where a rail's enable-and-ready term rises, and npor_o goes high at the edge of the Nth tick after that.
- R3: While the hold-off is running, a rising good term on the other rail does not restart it.
- R4: A falling good term on either rail pulls npor_o low at that same edge and reloads the full hold-off. The output releases again N ticks later, if both rails are good by then.
- R5: An enable rising edge opens a 5 ms window (500 ticks by default) on that rail. During the window the rail counts as good, so npor_o goes high at once if the hold-off has expired and the other rail is good.
- R6: When a rail's window closes with its ready flag low, npor_o goes low. When that rail later becomes ready, npor_o returns high without a new hold-off.
- R7: If one rail is never enabled, npor_o stays low even after the other rail's hold-off has expired.
- R8: chip_rst_i, or both enables low, clears the hold-off and drives npor_o low at the next edge. After chip_rst_i is released with both rails still up, the hold-off starts again from the beginning.
- R9: npor_oe_o is always the inverse of npor_o, so the pin is driven only when reset is asserted.
- R10: dly_sel_i is sampled only when the hold-off is loaded. A change while the hold-off is running does not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_rst_i | input | 1 | Internal chip reset, synchronous, active high |
| en1_i | input | 1 | Rail 1 enable |
| en2_i | input | 1 | Rail 2 enable |
| rdy1_i | input | 1 | Rail 1 ready comparator |
| rdy2_i | input | 1 | Rail 2 ready comparator |
| dly_sel_i | input | 2 | Hold-off length code |
| tick_i | input | 1 | Timebase tick, one clock wide |
| npor_o | output | 1 | Power-good level; 0 means reset asserted |
| npor_oe_o | output | 1 | Pull-down drive enable for the open-drain pin |

## Verification
The hardest case to reach is the late rail. The first rail's hold-off has expired, the second rail has not yet been enabled, and its grace window then has to be watched through all 500 ticks. The ticks come with random gaps, so the edge where the window closes is not a fixed cycle. The stimulus first releases rail 1 with rail 2 off, then enables rail 2 with its ready flag held low. It counts the ticks it delivers and samples just before and just after the last one. A separate random phase toggles both ready flags against a bench model of the hold-off, so retriggers also land while a hold-off is part-way through.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [1:0] {
    DLY_DEF  = 2'b00,
    DLY_FAST = 2'b01,
    DLY_MID  = 2'b10,
    DLY_LONG = 2'b11
  } dly_sel_e;

  // round up to whole ticks, never zero
  function automatic int unsigned ns_to_ticks(input int unsigned ns, input int unsigned tick_ns);
    int unsigned t;
    t = (ns + tick_ns - 1) / tick_ns;
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/pgs_rail_mon.sv
module pgs_rail_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic rdy_i,
  output logic good_o,
  output logic en_rise_o,
  output logic good_rise_o,
  output logic good_fall_o
);
  logic en_q, good_q, good_d;

  assign good_d = en_i & rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      good_q <= 1'b0;
    end else if (clr_i) begin
      en_q   <= 1'b0;
      good_q <= 1'b0;
    end else begin
      en_q   <= en_i;
      good_q <= good_d;
    end
  end

  assign good_o      = good_q;
  assign en_rise_o   = en_i & ~en_q & ~clr_i;
  assign good_rise_o = good_d & ~good_q & ~clr_i;
  assign good_fall_o = ~good_d & good_q & ~clr_i;
endmodule

// File: rtl/pgs_mask_timer.sv
module pgs_mask_timer #(
  parameter int unsigned TICKS = 500,
  localparam int unsigned CW = $clog2(TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic trig_i,
  input  logic tick_i,
  output logic active_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (trig_i)                 cnt_q <= CW'(TICKS);
    else if (active_o && tick_i)     cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/pgs_delay_timer.sv
module pgs_delay_timer
  import pgs_pkg::*;
#(
  parameter int unsigned T_DEF  = 5000,
  parameter int unsigned T_FAST = 5,
  parameter int unsigned T_MID  = 10000,
  parameter int unsigned T_LONG = 20000,
  localparam int unsigned T_MAX = max4(T_DEF, T_FAST, T_MID, T_LONG),
  localparam int unsigned CW = $clog2(T_MAX + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     start_i,
  input  logic     retrig_i,
  input  logic     tick_i,
  input  dly_sel_e sel_i,
  output logic     done_o
);
  logic [CW-1:0] cnt_q, load_val;
  logic          busy_q, done_q;

  always_comb begin
    unique case (sel_i)
      DLY_FAST: load_val = CW'(T_FAST);
      DLY_MID:  load_val = CW'(T_MID);
      DLY_LONG: load_val = CW'(T_LONG);
      default:  load_val = CW'(T_DEF);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (retrig_i || (start_i && !busy_q && !done_q)) begin
      cnt_q  <= load_val;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q && tick_i) begin
      if (cnt_q == CW'(1)) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/pwr_good_seq.sv
module pwr_good_seq
  import pgs_pkg::*;
#(
  parameter int unsigned TICK_NS   = 10_000,
  parameter int unsigned FAST_NS   = 50_000,
  parameter int unsigned DEF_NS    = 50_000_000,
  parameter int unsigned MID_NS    = 100_000_000,
  parameter int unsigned LONG_NS   = 200_000_000,
  parameter int unsigned MASK_NS   = 5_000_000,
  localparam int unsigned N_RAIL   = 2,
  localparam int unsigned T_FAST   = ns_to_ticks(FAST_NS, TICK_NS),
  localparam int unsigned T_DEF    = ns_to_ticks(DEF_NS, TICK_NS),
  localparam int unsigned T_MID    = ns_to_ticks(MID_NS, TICK_NS),
  localparam int unsigned T_LONG   = ns_to_ticks(LONG_NS, TICK_NS),
  localparam int unsigned T_MASK   = ns_to_ticks(MASK_NS, TICK_NS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chip_rst_i,
  input  logic       en1_i,
  input  logic       en2_i,
  input  logic       rdy1_i,
  input  logic       rdy2_i,
  input  logic [1:0] dly_sel_i,
  input  logic       tick_i,
  output logic       npor_o,
  output logic       npor_oe_o
);
  logic [N_RAIL-1:0] en, rdy, good, en_rise, good_rise, good_fall, mask_act;
  logic              timer_clr, dly_done, release_ok;

  assign en  = {en2_i, en1_i};
  assign rdy = {rdy2_i, rdy1_i};

  for (genvar r = 0; r < N_RAIL; r++) begin : g_rail
    pgs_rail_mon u_mon (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (chip_rst_i),
      .en_i        (en[r]),
      .rdy_i       (rdy[r]),
      .good_o      (good[r]),
      .en_rise_o   (en_rise[r]),
      .good_rise_o (good_rise[r]),
      .good_fall_o (good_fall[r])
    );

    pgs_mask_timer #(.TICKS(T_MASK)) u_mask (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (chip_rst_i),
      .trig_i   (en_rise[r]),
      .tick_i   (tick_i),
      .active_o (mask_act[r])
    );
  end

  // chip reset or all rails off wins over any set event
  assign timer_clr = chip_rst_i | ~|en;

  pgs_delay_timer #(
    .T_DEF (T_DEF),
    .T_FAST(T_FAST),
    .T_MID (T_MID),
    .T_LONG(T_LONG)
  ) u_dly (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (timer_clr),
    .start_i  (|good_rise),
    .retrig_i (|good_fall),
    .tick_i   (tick_i),
    .sel_i    (dly_sel_e'(dly_sel_i)),
    .done_o   (dly_done)
  );

  assign release_ok = dly_done & (&(good | mask_act));
  assign npor_o     = release_ok;
  assign npor_oe_o  = ~release_ok;
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chip_rst_i,
  input logic       en1_i,
  input logic       en2_i,
  input logic       rdy1_i,
  input logic       rdy2_i,
  input logic       npor_o,
  input logic [1:0] mask_act_i
);
  assert_chip_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_i |=> !npor_o);

  assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en1_i && !en2_i) |=> !npor_o);

  assert_retrig_rail1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npor_o && en1_i && !rdy1_i && !mask_act_i[0] && !chip_rst_i) |=> !npor_o);

  assert_retrig_rail2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npor_o && en2_i && !rdy2_i && !mask_act_i[1] && !chip_rst_i) |=> !npor_o);

  assert_mask_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npor_o && en2_i && !$past(en2_i) && en1_i && rdy1_i && !chip_rst_i) |=> npor_o);
endmodule

bind pwr_good_seq pgs_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chip_rst_i (chip_rst_i),
  .en1_i      (en1_i),
  .en2_i      (en2_i),
  .rdy1_i     (rdy1_i),
  .rdy2_i     (rdy2_i),
  .npor_o     (npor_o),
  .mask_act_i (mask_act)
);

// File: tb/tb_pwr_good_seq.sv
module tb_pwr_good_seq;
  localparam int unsigned TICK_NS = 10_000;
  localparam int unsigned MASK_T  = 5_000_000 / TICK_NS;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       chip_rst_i = 1'b0;
  logic       en1_i = 1'b0, en2_i = 1'b0, rdy1_i = 1'b0, rdy2_i = 1'b0;
  logic [1:0] dly_sel_i = 2'b00;
  logic       tick_i = 1'b0;
  logic       npor_o, npor_oe_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  pwr_good_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .chip_rst_i(chip_rst_i),
    .en1_i(en1_i), .en2_i(en2_i), .rdy1_i(rdy1_i), .rdy2_i(rdy2_i),
    .dly_sel_i(dly_sel_i), .tick_i(tick_i),
    .npor_o(npor_o), .npor_oe_o(npor_oe_o)
  );

  function automatic int unsigned dly_ticks(input logic [1:0] sel);
    case (sel)
      2'b01:   return 50_000 / TICK_NS;
      2'b10:   return 100_000_000 / TICK_NS;
      2'b11:   return 200_000_000 / TICK_NS;
      default: return 50_000_000 / TICK_NS;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit t);
    tick_i = t;
    @(posedge clk_i);
    #1;
    tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    int given = 0;
    while (given < n) begin
      bit t = ($urandom_range(0, 3) != 0);
      cyc(t);
      if (t) given++;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150_000) @(posedge clk_i);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt_m;
    bit run_m, done_m, g1, g2;
    void'($urandom(32'd20240611));

    // R1 reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 npor in reset", npor_o, 1'b0);
    chk("R1 oe in reset", npor_oe_o, 1'b1);
    rst_ni = 1'b1;
    cyc(1);
    chk("R1 npor after reset", npor_o, 1'b0);

    // R2/R3/R10 fast delay, second rail rise ignored, sel change ignored
    dly_sel_i = 2'b01;
    en1_i = 1; en2_i = 1;
    cyc(1);
    chk("R2 low before any ready", npor_o, 1'b0);
    rdy1_i = 1;
    cyc(0);
    dly_sel_i = 2'b11;
    ticks(2);
    rdy2_i = 1;
    cyc(1);
    ticks(1);
    chk("R3 low one tick before expiry", npor_o, 1'b0);
    ticks(1);
    chk("R3 high at expiry, no restart", npor_o, 1'b1);
    chk("R10 length fixed at load", npor_o, 1'b1);
    chk("R9 oe released", npor_oe_o, 1'b0);

    // R4 retrigger on ready drop
    dly_sel_i = 2'b01;
    rdy1_i = 0;
    cyc(0);
    chk("R4 low at drop", npor_o, 1'b0);
    chk("R9 oe driven", npor_oe_o, 1'b1);
    rdy1_i = 1;
    cyc(1);
    ticks(3);
    chk("R4 low before reload expires", npor_o, 1'b0);
    ticks(1);
    chk("R4 high after full reload", npor_o, 1'b1);

    // R8 chip reset and restart
    chip_rst_i = 1;
    cyc(1);
    chk("R8 low after chip reset", npor_o, 1'b0);
    chip_rst_i = 0;
    cyc(1);
    ticks(4);
    chk("R8 restart still counting", npor_o, 1'b0);
    ticks(1);
    chk("R8 restart releases", npor_o, 1'b1);
    en1_i = 0; en2_i = 0;
    cyc(0);
    chk("R8 low when both off", npor_o, 1'b0);

    // R7/R5/R6 late rail
    chip_rst_i = 1;
    en1_i = 1; rdy1_i = 1; en2_i = 0; rdy2_i = 0;
    cyc(0);
    chip_rst_i = 0;
    cyc(0);
    ticks(5);
    chk("R7 low with rail 2 never on", npor_o, 1'b0);
    ticks(600);
    chk("R7 still low later", npor_o, 1'b0);
    en2_i = 1;
    cyc(0);
    chk("R5 high at enable of late rail", npor_o, 1'b1);
    ticks(MASK_T / 2);
    chk("R5 high mid window", npor_o, 1'b1);
    ticks(MASK_T - MASK_T / 2 - 1);
    chk("R5 high last window tick", npor_o, 1'b1);
    ticks(1);
    chk("R6 low when window closes unready", npor_o, 1'b0);
    rdy2_i = 1;
    cyc(0);
    chk("R6 high once rail ready", npor_o, 1'b1);

    // R2 long codes
    for (int k = 0; k < 3; k++) begin
      logic [1:0] s = (k == 0) ? 2'b00 : (k == 1) ? 2'b10 : 2'b11;
      en1_i = 0; en2_i = 0;
      cyc(0);
      dly_sel_i = s;
      en1_i = 1; en2_i = 1; rdy1_i = 1; rdy2_i = 1;
      cyc(0);
      ticks(int'(dly_ticks(s)) - 1);
      chk($sformatf("R2 code %b low before expiry", s), npor_o, 1'b0);
      ticks(1);
      chk($sformatf("R2 code %b high at expiry", s), npor_o, 1'b1);
    end

    // random ready toggles against model (R4)
    dly_sel_i = 2'b01;
    cnt_m = 0; run_m = 0; done_m = 1; g1 = 1; g2 = 1;
    for (int i = 0; i < 400; i++) begin
      bit r1 = ($urandom_range(0, 9) != 0);
      bit r2 = ($urandom_range(0, 9) != 0);
      bit t  = ($urandom_range(0, 1) != 0);
      bit f  = (g1 & ~r1) | (g2 & ~r2);
      bit rs = (~g1 & r1) | (~g2 & r2);
      if (f) begin
        cnt_m = int'(dly_ticks(2'b01)); run_m = 1; done_m = 0;
      end else if (rs && !run_m && !done_m) begin
        cnt_m = int'(dly_ticks(2'b01)); run_m = 1;
      end else if (run_m && t) begin
        if (cnt_m == 1) begin run_m = 0; done_m = 1; end
        else cnt_m--;
      end
      g1 = r1; g2 = r2;
      rdy1_i = r1; rdy2_i = r2;
      cyc(t);
      chk("R4 random retrigger", npor_o, done_m & r1 & r2);
      chk("R9 random oe", npor_oe_o, ~(done_m & r1 & r2));
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule